// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block keeps wall-clock time from seconds up to a three-digit year and advances it once per second. The one-second strobe comes from a prescaler that counts pulses of a slow reference enable (32768 per second by default). The prescaler starts a fresh full count each time the master run enable is switched on. Seconds, minutes and hours carry into a day advance. The day advance moves the day of the week and the day of the month. Month lengths, including February in leap years, decide when the month and then the year move on.

Every field is held in binary and shown on its own output as BCD. Software loads a field by presenting BCD data, a field select and a one-cycle write strobe. Writes take effect only while the run enable is high. Writes are single-cycle control strobes with no handshake: the block accepts every strobe in the cycle it is presented and never applies back-pressure. The month is held internally as 0 to 11 but is read and written as BCD 1 to 12. The year is three BCD digits and counts full years from 1900.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the seconds, minutes, hours, day-of-week and day-of-month outputs read 00, the month output reads 01, the year output reads 000 and sec_tick is low.
- R2: While run_en is high, sec_tick is high in the cycle of every PRESCALE-th ref_pulse. With run_en low the count holds and sec_tick stays low. On a rising run_en the count restarts, so the PRESCALE-th ref_pulse after the rise gives the next tick. A ref_pulse in the rising cycle itself is not counted.
- R3: On each tick the seconds advance. 59 wraps to 00 and carries into the minutes, 59 minutes wrap and carry into the hours, and 23 hours wrap to 00 and start a new day.
- R4: On each new day the day of week advances and wraps from 6 to 0.
- R5: On a new day the day of month advances. Past the month's length it returns to 1 and the month advances. April, June, September and November have 30 days, February has 28, and the other months have 31.
- R6: February has 29 days when the full year (stored year plus 1900) is divisible by 4 and is either not divisible by 100 or divisible by 400.
- R7: Advancing past December gives January and increments the year. The stored year wraps from 999 to 000.
- R8: mon_bcd shows the internal month 0 to 11 as BCD 01 to 12. A month write of BCD n stores n-1.
- R9: year_bcd holds the two low year digits as BCD in bits 7:0 and the hundreds digit in bits 11:8. A year write uses the same layout.
- R10: Field writes use wr_sel = 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month and 6 year. Value 7 selects nothing. A write lands at the next clock edge, and only if run_en is high. Otherwise all fields keep their values.
- R11: A day of month of 0 becomes 1 at the next day advance, and the month does not change.
- R12: A write in the same cycle as a tick takes precedence: the written field takes the new value and that second's advance is dropped for all fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_pulse | input | 1 | One-cycle reference enable counted by the prescaler |
| run_en | input | 1 | Master run enable; gates counting and writes |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 3 | Field select for a write |
| wr_data | input | 12 | BCD write data (bits 11:8 used by the year only) |
| sec_tick | output | 1 | One-second strobe from the prescaler |
| sec_bcd | output | 8 | Seconds, BCD |
| min_bcd | output | 8 | Minutes, BCD |
| hour_bcd | output | 8 | Hours, BCD |
| wday_bcd | output | 8 | Day of week 0-6, BCD |
| mday_bcd | output | 8 | Day of month, BCD |
| mon_bcd | output | 8 | Month 01-12, BCD |
| year_bcd | output | 12 | Three-digit year, BCD |

## Verification
Calendar advances are exercised from the second before midnight at several chosen dates. These are the end of a 30-day and a 31-day month, February in a common year, in a year divisible by 4, in 2000 and in 2100, and New Year's Eve in year 199 and year 999. Together they tell the leap rule apart from a plain divisible-by-4 test, and the month carry apart from the year carry and the year wrap. The prescaler is tried with uninterrupted pulses, with run_en held low, and with run_en dropped partway through a count and raised again. These show whether the count holds and whether it restarts from full. Writes are tried with run_en low, with a day of 0, and in the exact cycle of a tick, which shows the gating, the forced day and the write precedence.

// File: rtl/rtc_cal_pkg.sv
`timescale 1ns/1ps
package rtc_cal_pkg;

  typedef enum logic [2:0] {
    SEL_SEC  = 3'd0,
    SEL_MIN  = 3'd1,
    SEL_HOUR = 3'd2,
    SEL_WDAY = 3'd3,
    SEL_MDAY = 3'd4,
    SEL_MON  = 3'd5,
    SEL_YEAR = 3'd6,
    SEL_NONE = 3'd7
  } field_sel_t;

  localparam int FW = 8;   // binary width of the small fields
  localparam int YW = 10;  // binary width of the year (0..999)

  localparam logic [FW-1:0] SEC_LAST  = FW'(59);
  localparam logic [FW-1:0] MIN_LAST  = FW'(59);
  localparam logic [FW-1:0] HOUR_LAST = FW'(23);
  localparam logic [FW-1:0] WDAY_LAST = FW'(6);
  localparam logic [FW-1:0] MON_LAST  = FW'(11);
  localparam logic [YW-1:0] YEAR_LAST = YW'(999);
  localparam logic [11:0]   YEAR_BASE = 12'd1900;

  function automatic logic [7:0] bin2bcd(input logic [7:0] v);
    logic [7:0] t;
    logic [7:0] u;
    t = (v / 8'd10) % 8'd10;
    u = v % 8'd10;
    return {t[3:0], u[3:0]};
  endfunction

  function automatic logic [7:0] bcd2bin(input logic [7:0] b);
    return ({4'b0, b[7:4]} * 8'd10) + {4'b0, b[3:0]};
  endfunction

  function automatic logic [11:0] year2bcd(input logic [YW-1:0] y);
    logic [YW-1:0] h;
    logic [YW-1:0] lo;
    h  = (y / 10'd100) % 10'd10;
    lo = y % 10'd100;
    return {h[3:0], bin2bcd(lo[7:0])};
  endfunction

  function automatic logic [YW-1:0] bcd2year(input logic [11:0] b);
    return {2'b0, bcd2bin(b[7:0])} + ({6'b0, b[11:8]} * 10'd100);
  endfunction

  function automatic logic is_leap(input logic [YW-1:0] y);
    logic [11:0] f;
    f = YEAR_BASE + {2'b0, y};
    return ((f % 12'd4) == 12'd0) &&
           (((f % 12'd100) != 12'd0) || ((f % 12'd400) == 12'd0));
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] m, input logic leap);
    case (m)
      8'd1:                     month_len = leap ? 8'd29 : 8'd28;
      8'd3, 8'd5, 8'd8, 8'd10:  month_len = 8'd30;
      default:                  month_len = 8'd31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
`timescale 1ns/1ps
module rtc_prescaler #(
  parameter int PRESCALE = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic ref_pulse,
  output logic tick
);
  localparam int CW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [CW-1:0] LOAD = CW'(PRESCALE - 1);

  logic [CW-1:0] cnt;
  logic          run_q;
  logic          restart;

  assign restart = run_en & ~run_q;
  assign tick    = run_en & run_q & ref_pulse & (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= LOAD;
      run_q <= 1'b0;
    end else begin
      run_q <= run_en;
      if (restart)
        cnt <= LOAD;
      else if (run_en && ref_pulse)
        cnt <= (cnt == '0) ? LOAD : cnt - 1'b1;
    end
  end
endmodule

// File: rtl/rtc_hms_chain.sv
`timescale 1ns/1ps
module rtc_hms_chain
  import rtc_cal_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          wr_sec,
  input  logic          wr_min,
  input  logic          wr_hour,
  input  logic [FW-1:0] wbin,
  output logic [FW-1:0] sec,
  output logic [FW-1:0] min,
  output logic [FW-1:0] hour,
  output logic          day_adv
);
  logic min_adv;
  logic hour_adv;

  assign min_adv  = adv & (sec >= SEC_LAST);
  assign hour_adv = min_adv & (min >= MIN_LAST);
  assign day_adv  = hour_adv & (hour >= HOUR_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec  <= '0;
      min  <= '0;
      hour <= '0;
    end else begin
      if (wr_sec)       sec <= wbin;
      else if (adv)     sec <= min_adv ? '0 : sec + 1'b1;

      if (wr_min)       min <= wbin;
      else if (min_adv) min <= hour_adv ? '0 : min + 1'b1;

      if (wr_hour)       hour <= wbin;
      else if (hour_adv) hour <= day_adv ? '0 : hour + 1'b1;
    end
  end
endmodule

// File: rtl/rtc_date_chain.sv
`timescale 1ns/1ps
module rtc_date_chain
  import rtc_cal_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          day_adv,
  input  logic          wr_wday,
  input  logic          wr_mday,
  input  logic          wr_mon,
  input  logic          wr_year,
  input  logic [FW-1:0] wbin,
  input  logic [FW-1:0] wmon,
  input  logic [YW-1:0] wyear,
  output logic [FW-1:0] wday,
  output logic [FW-1:0] mday,
  output logic [FW-1:0] mon,
  output logic [YW-1:0] year
);
  logic [FW-1:0] mday_nxt;
  logic [FW-1:0] mlen;
  logic          mon_adv;
  logic          year_adv;

  assign mlen     = month_len(mon, is_leap(year));
  assign mday_nxt = mday + 1'b1;
  assign mon_adv  = day_adv & (mday_nxt > mlen);
  assign year_adv = mon_adv & (mon >= MON_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wday <= '0;
      mday <= '0;
      mon  <= '0;
      year <= '0;
    end else begin
      if (wr_wday)      wday <= wbin;
      else if (day_adv) wday <= (wday >= WDAY_LAST) ? '0 : wday + 1'b1;

      if (wr_mday)      mday <= wbin;
      else if (day_adv) mday <= mon_adv ? FW'(1) : mday_nxt;

      if (wr_mon)       mon <= wmon;
      else if (mon_adv) mon <= year_adv ? '0 : mon + 1'b1;

      if (wr_year)       year <= wyear;
      else if (year_adv) year <= (year >= YEAR_LAST) ? '0 : year + 1'b1;
    end
  end
endmodule

// File: rtl/rtc_calendar.sv
`timescale 1ns/1ps
module rtc_calendar
  import rtc_cal_pkg::*;
#(
  parameter int PRESCALE = 32768
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ref_pulse,
  input  logic        run_en,
  input  logic        wr_en,
  input  logic [2:0]  wr_sel,
  input  logic [11:0] wr_data,
  output logic        sec_tick,
  output logic [7:0]  sec_bcd,
  output logic [7:0]  min_bcd,
  output logic [7:0]  hour_bcd,
  output logic [7:0]  wday_bcd,
  output logic [7:0]  mday_bcd,
  output logic [7:0]  mon_bcd,
  output logic [11:0] year_bcd
);
  localparam int NSEL = 7;

  field_sel_t    sel;
  logic          wr_act;
  logic          adv;
  logic [NSEL-1:0] wr_hit;
  logic [FW-1:0] wbin;
  logic [FW-1:0] wmon;
  logic [YW-1:0] wyear;
  logic          day_adv;
  logic [FW-1:0] sec, min, hour, wday, mday, mon;
  logic [YW-1:0] year;

  assign sel    = field_sel_t'(wr_sel);
  assign wr_act = wr_en & run_en & (sel != SEL_NONE);
  assign adv    = sec_tick & ~wr_act;

  for (genvar g = 0; g < NSEL; g++) begin : g_dec
    assign wr_hit[g] = wr_act & (wr_sel == 3'(g));
  end

  assign wbin  = bcd2bin(wr_data[7:0]);
  assign wmon  = wbin - 1'b1;
  assign wyear = bcd2year(wr_data);

  rtc_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_en    (run_en),
    .ref_pulse (ref_pulse),
    .tick      (sec_tick)
  );

  rtc_hms_chain u_hms (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (adv),
    .wr_sec  (wr_hit[SEL_SEC]),
    .wr_min  (wr_hit[SEL_MIN]),
    .wr_hour (wr_hit[SEL_HOUR]),
    .wbin    (wbin),
    .sec     (sec),
    .min     (min),
    .hour    (hour),
    .day_adv (day_adv)
  );

  rtc_date_chain u_date (
    .clk     (clk),
    .rst_n   (rst_n),
    .day_adv (day_adv),
    .wr_wday (wr_hit[SEL_WDAY]),
    .wr_mday (wr_hit[SEL_MDAY]),
    .wr_mon  (wr_hit[SEL_MON]),
    .wr_year (wr_hit[SEL_YEAR]),
    .wbin    (wbin),
    .wmon    (wmon),
    .wyear   (wyear),
    .wday    (wday),
    .mday    (mday),
    .mon     (mon),
    .year    (year)
  );

  assign sec_bcd  = bin2bcd(sec);
  assign min_bcd  = bin2bcd(min);
  assign hour_bcd = bin2bcd(hour);
  assign wday_bcd = bin2bcd(wday);
  assign mday_bcd = bin2bcd(mday);
  assign mon_bcd  = bin2bcd(mon + 1'b1);
  assign year_bcd = year2bcd(year);
endmodule

// File: rtl/rtc_calendar_chk.sv
`timescale 1ns/1ps
module rtc_calendar_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ref_pulse,
  input logic        run_en,
  input logic        wr_en,
  input logic [2:0]  wr_sel,
  input logic [11:0] wr_data,
  input logic        sec_tick,
  input logic [7:0]  sec_bcd,
  input logic [7:0]  min_bcd,
  input logic [7:0]  hour_bcd,
  input logic [7:0]  wday_bcd,
  input logic [7:0]  mday_bcd,
  input logic [7:0]  mon_bcd,
  input logic [11:0] year_bcd
);
  logic at_midnight;
  assign at_midnight = (hour_bcd == 8'h23) && (min_bcd == 8'h59) && (sec_bcd == 8'h59);

  p_tick_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |-> (run_en && ref_pulse));

  p_sec_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !wr_en && sec_bcd == 8'h59) |=> (sec_bcd == 8'h00));

  p_wday_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !wr_en && at_midnight && wday_bcd == 8'h06) |=> (wday_bcd == 8'h00));

  p_new_year_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !wr_en && at_midnight && mon_bcd == 8'h12 && mday_bcd == 8'h31)
      |=> (mon_bcd == 8'h01 && mday_bcd == 8'h01));

  p_hold_stopped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en) |=> $stable({sec_bcd, min_bcd, hour_bcd, wday_bcd, mday_bcd, mon_bcd, year_bcd}));

  p_write_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && run_en && wr_sel == 3'd0 && wr_data[7:4] <= 4'd5 && wr_data[3:0] <= 4'd9)
      |=> (sec_bcd == $past(wr_data[7:0])));
endmodule

bind rtc_calendar rtc_calendar_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ref_pulse (ref_pulse),
  .run_en    (run_en),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .wr_data   (wr_data),
  .sec_tick  (sec_tick),
  .sec_bcd   (sec_bcd),
  .min_bcd   (min_bcd),
  .hour_bcd  (hour_bcd),
  .wday_bcd  (wday_bcd),
  .mday_bcd  (mday_bcd),
  .mon_bcd   (mon_bcd),
  .year_bcd  (year_bcd)
);

// File: tb/rtc_calendar_test.sv
`timescale 1ns/1ps
module rtc_calendar_test;
  localparam int P = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_pulse = 1'b0;
  logic run_en = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_sel = 3'd7;
  logic [11:0] wr_data = '0;
  logic sec_tick;
  logic [7:0] sec_bcd, min_bcd, hour_bcd, wday_bcd, mday_bcd, mon_bcd;
  logic [11:0] year_bcd;

  always #2.5 clk = ~clk;

  rtc_calendar #(.PRESCALE(P)) uut (
    .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .run_en(run_en),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .sec_tick(sec_tick),
    .sec_bcd(sec_bcd), .min_bcd(min_bcd), .hour_bcd(hour_bcd), .wday_bcd(wday_bcd),
    .mday_bcd(mday_bcd), .mon_bcd(mon_bcd), .year_bcd(year_bcd)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // bench model of the calendar in plain integers
  int s = 0, m = 0, h = 0, wd = 0, md = 0, mo = 0, yr = 0;

  logic [59:0] exp_q[$];
  string       tag_q[$];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] to_bcd(input int v);
    return 8'(((v / 10) % 10) * 16 + (v % 10));
  endfunction

  function automatic int from_bcd(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic int mlen(input int mon, input int year);
    int fy;
    fy = year + 1900;
    if (mon == 1) return ((fy % 4 == 0) && ((fy % 100 != 0) || (fy % 400 == 0))) ? 29 : 28;
    if (mon == 3 || mon == 5 || mon == 8 || mon == 10) return 30;
    return 31;
  endfunction

  function automatic logic [59:0] model_pack();
    logic [11:0] y;
    y = 12'(((yr / 100) % 10) * 256 + ((yr % 100) / 10) * 16 + (yr % 10));
    return {y, to_bcd(mo + 1), to_bcd(md), to_bcd(wd), to_bcd(h), to_bcd(m), to_bcd(s)};
  endfunction

  task automatic model_tick();
    s++;
    if (s >= 60) begin
      s = 0; m++;
      if (m >= 60) begin
        m = 0; h++;
        if (h >= 24) begin
          h = 0;
          wd = (wd >= 6) ? 0 : wd + 1;
          md++;
          if (md > mlen(mo, yr)) begin
            md = 1; mo++;
            if (mo >= 12) begin
              mo = 0;
              yr = (yr >= 999) ? 0 : yr + 1;
            end
          end
        end
      end
    end
  endtask

  task automatic model_write(input logic [2:0] sel, input logic [11:0] d);
    case (sel)
      3'd0: s  = from_bcd(d[7:0]);
      3'd1: m  = from_bcd(d[7:0]);
      3'd2: h  = from_bcd(d[7:0]);
      3'd3: wd = from_bcd(d[7:0]);
      3'd4: md = from_bcd(d[7:0]);
      3'd5: mo = from_bcd(d[7:0]) - 1;
      3'd6: yr = from_bcd(d[7:0]) + int'(d[11:8]) * 100;
      default: ;
    endcase
  endtask

  function automatic logic [59:0] dut_pack();
    return {year_bcd, mon_bcd, mday_bcd, wday_bcd, hour_bcd, min_bcd, sec_bcd};
  endfunction

  // monitor: pops one expectation per observed tick and compares the fields
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && sec_tick) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          chk("R2 unexpected tick", 64'(dut_pack()), 64'd0);
        end else begin
          logic [59:0] e;
          logic [59:0] a;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          a = dut_pack();
          chk({t, " sec"},  64'(a[7:0]),   64'(e[7:0]));
          chk({t, " min"},  64'(a[15:8]),  64'(e[15:8]));
          chk({t, " hour"}, 64'(a[23:16]), 64'(e[23:16]));
          chk({t, " wday"}, 64'(a[31:24]), 64'(e[31:24]));
          chk({t, " mday"}, 64'(a[39:32]), 64'(e[39:32]));
          chk({t, " mon"},  64'(a[47:40]), 64'(e[47:40]));
          chk({t, " year"}, 64'(a[59:48]), 64'(e[59:48]));
        end
      end
    end
  end

  task automatic pulse(output logic t);
    @(posedge clk); #1 ref_pulse = 1'b1;
    @(negedge clk); t = sec_tick;
    @(posedge clk); #1 ref_pulse = 1'b0;
  endtask

  task automatic one_second(input string tag);
    logic t;
    model_tick();
    exp_q.push_back(model_pack());
    tag_q.push_back(tag);
    for (int i = 0; i < P; i++) begin
      pulse(t);
      chk("R2 tick on last pulse", 64'(t), 64'(i == P - 1));
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [11:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    if (run_en) model_write(sel, d);
    @(posedge clk); #1;
    wr_en = 1'b0; wr_sel = 3'd7;
  endtask

  task automatic set_time(input logic [11:0] y, input logic [7:0] mon, input logic [7:0] day,
                          input logic [7:0] dow, input logic [7:0] hh, input logic [7:0] mm,
                          input logic [7:0] ss);
    wr(3'd6, y);
    wr(3'd5, {4'h0, mon});
    wr(3'd4, {4'h0, day});
    wr(3'd3, {4'h0, dow});
    wr(3'd2, {4'h0, hh});
    wr(3'd1, {4'h0, mm});
    wr(3'd0, {4'h0, ss});
  endtask

  task automatic check_all(input string tag);
    logic [59:0] e;
    @(negedge clk);
    e = model_pack();
    chk({tag, " sec"},  64'(sec_bcd),  64'(e[7:0]));
    chk({tag, " min"},  64'(min_bcd),  64'(e[15:8]));
    chk({tag, " hour"}, 64'(hour_bcd), 64'(e[23:16]));
    chk({tag, " wday"}, 64'(wday_bcd), 64'(e[31:24]));
    chk({tag, " mday"}, 64'(mday_bcd), 64'(e[39:32]));
    chk({tag, " mon"},  64'(mon_bcd),  64'(e[47:40]));
    chk({tag, " year"}, 64'(year_bcd), 64'(e[59:48]));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic t;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset values
    @(negedge clk);
    chk("R1 tick", 64'(sec_tick), 64'd0);
    check_all("R1");
    chk("R1 month reads 01", 64'(mon_bcd), 64'h01);

    // R10: writes ignored while stopped
    wr(3'd0, 12'h030);
    wr(3'd6, 12'h123);
    check_all("R10 gated");
    chk("R10 sec unchanged", 64'(sec_bcd), 64'h00);

    @(posedge clk); #1 run_en = 1'b1;
    repeat (2) @(posedge clk);

    // R8 R9: write and read back
    set_time(12'h123, 8'h02, 8'h28, 8'h06, 8'h23, 8'h59, 8'h58);
    check_all("R8 R9 readback");
    chk("R8 month", 64'(mon_bcd), 64'h02);
    chk("R9 year", 64'(year_bcd), 64'h123);

    // R3 R4 R5: common-year February end, wday 6 -> 0
    one_second("R3");
    one_second("R3 R4 R5 Feb 2023");

    // R6: leap years
    set_time(12'h124, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
    one_second("R6 2024 Feb 29");
    wr(3'd2, 12'h023); wr(3'd1, 12'h059); wr(3'd0, 12'h059);
    one_second("R6 2024 Mar 1");
    set_time(12'h100, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59);
    one_second("R6 2000 Feb 29");
    set_time(12'h200, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
    one_second("R6 2100 Mar 1");

    // R5: 30- and 31-day months
    set_time(12'h150, 8'h04, 8'h30, 8'h04, 8'h23, 8'h59, 8'h59);
    one_second("R5 Apr 30");
    set_time(12'h150, 8'h01, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59);
    one_second("R5 Jan 31");
    set_time(12'h150, 8'h07, 8'h30, 8'h05, 8'h23, 8'h59, 8'h59);
    one_second("R5 Jul 30");

    // R7: year carry and wrap
    set_time(12'h199, 8'h12, 8'h31, 8'h06, 8'h23, 8'h59, 8'h59);
    one_second("R7 new year");
    chk("R9 year digits", 64'(year_bcd), 64'h200);
    set_time(12'h999, 8'h12, 8'h31, 8'h00, 8'h23, 8'h59, 8'h59);
    one_second("R7 year wrap");

    // R11: day 0 forced to 1
    set_time(12'h124, 8'h07, 8'h00, 8'h02, 8'h23, 8'h59, 8'h59);
    one_second("R11 day zero");
    chk("R11 month kept", 64'(mon_bcd), 64'h07);

    // R2: held while stopped
    @(posedge clk); #1 run_en = 1'b0;
    for (int i = 0; i < 2 * P; i++) begin
      pulse(t);
      chk("R2 held stopped", 64'(t), 64'd0);
    end
    check_all("R2 stopped");

    // R2: restart from full count after re-enable
    @(posedge clk); #1 run_en = 1'b1;
    repeat (2) @(posedge clk);
    one_second("R2 realign");
    for (int i = 0; i < P - 1; i++) begin
      pulse(t);
      chk("R2 partial", 64'(t), 64'd0);
    end
    @(posedge clk); #1 run_en = 1'b0;
    @(posedge clk); #1 run_en = 1'b1;
    @(posedge clk);
    one_second("R2 restart");

    // R12: write in the tick cycle
    for (int i = 0; i < P - 1; i++) pulse(t);
    @(posedge clk); #1;
    ref_pulse = 1'b1; wr_en = 1'b1; wr_sel = 3'd0; wr_data = 12'h007;
    model_write(3'd0, 12'h007);
    exp_q.push_back(model_pack());
    tag_q.push_back("R12 write wins");
    @(negedge clk);
    chk("R12 tick present", 64'(sec_tick), 64'd1);
    @(posedge clk); #1;
    ref_pulse = 1'b0; wr_en = 1'b0; wr_sel = 3'd7;

    repeat (6) @(posedge clk);
    chk("R2 queue drained", 64'(exp_q.size()), 64'd0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule